// File: doc/BRIEF.md
# Raw VBI Line Capture Framer

This block picks which video lines are passed on as raw vertical-blanking data. It then sends each picked line downstream as a framed byte stream. It watches a sample-rate byte stream, a one-cycle pulse marking the half-amplitude point of the horizontal sync leading edge, the current field identity, a 9-bit line number and a flag that marks equalization and serration lines. A small register set controls it through a simple write port: a control word, a start offset, a slot limit and a per-line selection mask.

For each picked line, the block skips a programmable number of sample beats after the sync pulse, counted in steps of two beats. It then emits one output byte per input beat until the slot limit is reached or the next sync pulse arrives. When the preamble is enabled, the first four slots of the line carry a header in place of the samples that would have filled them. The header is FFh, then a tagged upper-line/field byte, then a tagged lower-line byte, then 00h.

The input side has no ready signal, because a video source cannot pause. The output side is valid/ready. While `vbi_valid` is high and `vbi_ready` is low, the output byte and marker are held. Any sample slots that pass during the stall are lost, and the slot count still advances, so line timing stays fixed.

Top module: `vbi_raw_framer`

## Requirements
- R1: After reset `vbi_valid` is low, all control bits are zero so no line is captured, the start offset register holds 7Ah and the slot limit holds 1440.
- R2: Control word bit 0 enables odd-field lines (`fld_even`=0) and bit 1 enables even-field lines (`fld_even`=1). A line of a disabled field produces no output.
- R3: With control bit 2 (capture-all) set, every line of an enabled field is captured except those with `eq_line` high.
- R4: With capture-all clear, a line is captured only if its mask bit (indexed by `line_num`) is set.
- R5: Beats are counted from the first beat after the sync pulse cycle, and the sample in the pulse cycle is never used. Beat number 2×start (0-based) fills slot 0, and each later beat fills the next slot.
- R6: With control bit 3 (preamble) set, slots 0..3 carry FFh, CNT1, CNT2 and 00h in that order, and the samples on those beats are discarded. Slot 4 onward carries samples.
- R7: CNT1 bits 5..0 are {field flag (1 = even), line bits 8..4}. CNT2 bits 5..0 are {00, line bits 3..0}. In each of them bit 6 is the XOR of bits 5..0 and bit 7 is its inverse.
- R8: A line emits at most the slot-limit number of bytes, and emission stops at the next sync pulse.
- R9: `vbi_sol` is high with slot 0 of each line and low on every other byte.
- R10: Control, offset, limit, field, line number and flag are sampled at the sync pulse. Register writes during a line do not affect that line.
- R11: While `vbi_valid` is high and `vbi_ready` is low, `vbi_valid`, `vbi_data` and `vbi_sol` hold. Slots that arrive during the stall are dropped.
- R12: Cycles with `smp_valid` low are not beats and advance nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample beat qualifier |
| smp_data | input | 8 | Sample byte |
| hs_mid | input | 1 | One-cycle pulse at sync edge midpoint |
| fld_even | input | 1 | Current field is even |
| line_num | input | 9 | Current line number |
| eq_line | input | 1 | Line is an equalization/serration line |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 start, 2 slot limit |
| cfg_wdata | input | 16 | Register write data |
| mask_we | input | 1 | Line mask write strobe |
| mask_line | input | 9 | Line mask index |
| mask_bit | input | 1 | Line mask write value |
| vbi_valid | output | 1 | Output byte valid |
| vbi_ready | input | 1 | Downstream ready |
| vbi_data | output | 8 | Output byte |
| vbi_sol | output | 1 | Start-of-line marker |

## Verification
The bench uses a two-beat start step. If the design counted the offset in single beats or counted the pulse cycle itself, the first byte would be shifted by one or more samples. It checks header bytes for both odd and even parity of the tagged fields; a swapped parity bit or a field flag in the wrong position would corrupt CNT1 or CNT2. It also changes registers in the middle of a line and stalls the output. A design that does not snapshot at the pulse would cut the line short, and one that queues during a stall would deliver the dropped beats.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam int VBI_LINE_W = 9;

  typedef struct packed {
    logic hdr_en;
    logic all_lines;
    logic even_en;
    logic odd_en;
  } vbi_ctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_LIMIT = 2'd2
  } vbi_sel_e;

  // 6 payload bits, bit6 = parity (XOR), bit7 = its complement
  function automatic logic [7:0] tag_byte(input logic [5:0] payload);
    logic p;
    p = ^payload;
    return {~p, p, payload};
  endfunction
endpackage

// File: rtl/vbi_cfg_regs.sv
module vbi_cfg_regs
  import vbi_pkg::*;
#(
  parameter int START_W   = 8,
  parameter int LIMIT_W   = 12,
  parameter logic [START_W-1:0] START_RST = 8'h7A,
  parameter logic [LIMIT_W-1:0] LIMIT_RST = 12'd1440
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [15:0]           cfg_wdata,
  input  logic                  mask_we,
  input  logic [VBI_LINE_W-1:0] mask_line,
  input  logic                  mask_bit,
  input  logic [VBI_LINE_W-1:0] rd_line,
  output vbi_ctrl_t             ctrl,
  output logic [START_W-1:0]    start_ofs,
  output logic [LIMIT_W-1:0]    slot_lim,
  output logic                  rd_mask
);
  localparam int NLINES = 1 << VBI_LINE_W;

  logic [NLINES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      start_ofs <= START_RST;
      slot_lim  <= LIMIT_RST;
    end else if (cfg_we) begin
      case (vbi_sel_e'(cfg_sel))
        SEL_CTRL:  ctrl      <= vbi_ctrl_t'(cfg_wdata[3:0]);
        SEL_START: start_ofs <= cfg_wdata[START_W-1:0];
        SEL_LIMIT: slot_lim  <= cfg_wdata[LIMIT_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_we) mask_q[mask_line] <= mask_bit;
  end

  assign rd_mask = mask_q[rd_line];

  // R1
  reset_ctrl_chk: assert property (@(posedge clk) $rose(rst_n) |-> (ctrl == '0 && start_ofs == START_RST));
endmodule

// File: rtl/vbi_line_sel.sv
module vbi_line_sel
  import vbi_pkg::*;
(
  input  vbi_ctrl_t             ctrl,
  input  logic                  fld_even,
  input  logic [VBI_LINE_W-1:0] line_num,
  input  logic                  eq_line,
  input  logic                  mask_hit,
  output logic                  pick,
  output logic                  fld_ok,
  output logic [7:0]            hdr1,
  output logic [7:0]            hdr2
);
  always_comb begin
    fld_ok = fld_even ? ctrl.even_en : ctrl.odd_en;
    pick   = fld_ok && (ctrl.all_lines ? !eq_line : mask_hit);
    hdr1   = tag_byte({fld_even, line_num[8:4]});
    hdr2   = tag_byte({2'b00, line_num[3:0]});
  end
endmodule

// File: rtl/vbi_framer.sv
module vbi_framer
  import vbi_pkg::*;
#(
  parameter int START_W = 8,
  parameter int LIMIT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [7:0]         smp_data,
  input  logic               hs_mid,
  input  logic               pick,
  input  logic               fld_ok,
  input  logic               hdr_en,
  input  logic [7:0]         hdr1,
  input  logic [7:0]         hdr2,
  input  logic [START_W-1:0] start_ofs,
  input  logic [LIMIT_W-1:0] slot_lim,
  output logic               vbi_valid,
  input  logic               vbi_ready,
  output logic [7:0]         vbi_data,
  output logic               vbi_sol
);
  localparam int SKIP_W = START_W + 1;

  logic               active_q, fld_ok_q, hdr_q;
  logic [7:0]         hdr1_q, hdr2_q;
  logic [SKIP_W-1:0]  skip_cnt, skip_end;
  logic [LIMIT_W-1:0] slot_cnt, lim_q;
  logic               skip_done, room, emit, in_hdr;
  logic [7:0]         slot_byte;

  assign skip_done = (skip_cnt == skip_end);
  assign room      = (slot_cnt < lim_q);
  assign emit      = !hs_mid && smp_valid && active_q && skip_done && room;
  assign in_hdr    = hdr_q && (slot_cnt < LIMIT_W'(4));

  always_comb begin
    slot_byte = smp_data;
    if (in_hdr) begin
      case (slot_cnt[1:0])
        2'd0: slot_byte = 8'hFF;
        2'd1: slot_byte = hdr1_q;
        2'd2: slot_byte = hdr2_q;
        default: slot_byte = 8'h00;
      endcase
    end
  end

  // line state: snapshot at the pulse, then skip and slot counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fld_ok_q <= 1'b0;
      hdr_q    <= 1'b0;
      hdr1_q   <= '0;
      hdr2_q   <= '0;
      skip_cnt <= '0;
      skip_end <= '0;
      slot_cnt <= '0;
      lim_q    <= '0;
    end else if (hs_mid) begin
      active_q <= pick;
      fld_ok_q <= fld_ok;
      hdr_q    <= hdr_en;
      hdr1_q   <= hdr1;
      hdr2_q   <= hdr2;
      skip_cnt <= '0;
      skip_end <= {start_ofs, 1'b0};
      slot_cnt <= '0;
      lim_q    <= slot_lim;
    end else if (smp_valid && active_q) begin
      if (!skip_done) skip_cnt <= skip_cnt + 1'b1;
      else if (room)  slot_cnt <= slot_cnt + 1'b1;
    end
  end

  // output register, holds under back-pressure
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbi_valid <= 1'b0;
      vbi_data  <= '0;
      vbi_sol   <= 1'b0;
    end else if (!vbi_valid || vbi_ready) begin
      vbi_valid <= emit;
      vbi_data  <= slot_byte;
      vbi_sol   <= emit && (slot_cnt == '0);
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbi_valid && !vbi_ready |=> vbi_valid && $stable(vbi_data) && $stable(vbi_sol));
  // R8
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) slot_cnt <= lim_q);
  // R6
  hdr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbi_valid && vbi_sol && hdr_q && $stable(hdr_q) |-> vbi_data == 8'hFF);
  // R2
  field_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) emit |-> fld_ok_q);
endmodule

// File: rtl/vbi_raw_framer.sv
module vbi_raw_framer
  import vbi_pkg::*;
#(
  parameter int START_W = 8,
  parameter int LIMIT_W = 12,
  parameter logic [START_W-1:0] START_RST = 8'h7A,
  parameter logic [LIMIT_W-1:0] LIMIT_RST = 12'd1440
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [7:0]  smp_data,
  input  logic        hs_mid,
  input  logic        fld_even,
  input  logic [8:0]  line_num,
  input  logic        eq_line,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  input  logic        mask_we,
  input  logic [8:0]  mask_line,
  input  logic        mask_bit,
  output logic        vbi_valid,
  input  logic        vbi_ready,
  output logic [7:0]  vbi_data,
  output logic        vbi_sol
);
  vbi_ctrl_t          ctrl;
  logic [START_W-1:0] start_ofs;
  logic [LIMIT_W-1:0] slot_lim;
  logic               mask_hit, pick, fld_ok;
  logic [7:0]         hdr1, hdr2;

  vbi_cfg_regs #(
    .START_W(START_W), .LIMIT_W(LIMIT_W), .START_RST(START_RST), .LIMIT_RST(LIMIT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mask_we(mask_we), .mask_line(mask_line), .mask_bit(mask_bit), .rd_line(line_num),
    .ctrl(ctrl), .start_ofs(start_ofs), .slot_lim(slot_lim), .rd_mask(mask_hit)
  );

  vbi_line_sel u_sel (
    .ctrl(ctrl), .fld_even(fld_even), .line_num(line_num), .eq_line(eq_line),
    .mask_hit(mask_hit), .pick(pick), .fld_ok(fld_ok), .hdr1(hdr1), .hdr2(hdr2)
  );

  vbi_framer #(.START_W(START_W), .LIMIT_W(LIMIT_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data), .hs_mid(hs_mid),
    .pick(pick), .fld_ok(fld_ok), .hdr_en(ctrl.hdr_en), .hdr1(hdr1), .hdr2(hdr2),
    .start_ofs(start_ofs), .slot_lim(slot_lim), .vbi_valid(vbi_valid), .vbi_ready(vbi_ready),
    .vbi_data(vbi_data), .vbi_sol(vbi_sol)
  );
endmodule

// File: tb/vbi_raw_framer_test.sv
module vbi_raw_framer_test;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, hs_mid = 0, fld_even = 0, eq_line = 0;
  logic [7:0] smp_data = 0;
  logic [8:0] line_num = 0, mask_line = 0;
  logic cfg_we = 0, mask_we = 0, mask_bit = 0, vbi_ready = 1;
  logic [1:0] cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic vbi_valid, vbi_sol;
  logic [7:0] vbi_data;

  int checks = 0, errors = 0;
  bit sb_on = 1;
  string cur_tag = "R1";
  logic [8:0] expq[$];

  int m_start = 8'h7A, m_lim = 1440;
  bit m_odd = 0, m_even = 0, m_all = 0, m_hdr = 0;
  bit m_mask [512];

  always #2.5 clk = ~clk;

  vbi_raw_framer uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_tag(input logic [5:0] v);
    logic p;
    p = ^v;
    return {~p, p, v};
  endfunction

  function automatic logic [7:0] pat(input int j);
    return 8'(8'h30 + j * 5);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_on && rst_n && vbi_valid && vbi_ready) begin
      if (expq.size() == 0) chk(0, {cur_tag, " unexpected byte"}, {vbi_sol, vbi_data}, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({vbi_sol, vbi_data} == e, {cur_tag, " byte/sol"}, {vbi_sol, vbi_data}, e);
      end
    end
  end

  task automatic wr_cfg(input logic [1:0] s, input logic [15:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic set_ctrl(input bit o, input bit e, input bit a, input bit h);
    m_odd = o; m_even = e; m_all = a; m_hdr = h;
    wr_cfg(2'd0, {12'd0, h, a, e, o});
  endtask

  task automatic wr_mask(input int ln, input bit v);
    m_mask[ln] = v;
    @(posedge clk); #1; mask_we = 1; mask_line = 9'(ln); mask_bit = v;
    @(posedge clk); #1; mask_we = 0;
  endtask

  task automatic run_line(input bit fe, input int ln, input bit eq, input int nb,
                          input bit gaps, input bit midchg);
    bit s;
    int S, L, j, cyc, k;
    logic [7:0] h1, h2, b;
    s = (fe ? m_even : m_odd) && (m_all ? !eq : m_mask[ln]);
    S = 2 * m_start; L = m_lim;
    h1 = tb_tag({fe, 5'(ln >> 4)});
    h2 = tb_tag({2'b00, 4'(ln)});
    @(posedge clk); #1;
    hs_mid = 1; fld_even = fe; line_num = 9'(ln); eq_line = eq;
    smp_valid = 1; smp_data = 8'hEE;
    j = 0; cyc = 0;
    while (j < nb) begin
      @(posedge clk); #1;
      hs_mid = 0; cfg_we = 0;
      if (gaps && (cyc % 3 == 2)) begin
        smp_valid = 0; smp_data = 8'h99;
      end else begin
        smp_valid = 1; smp_data = pat(j);
        k = j - S;
        if (s && j >= S && k < L) begin
          if (m_hdr && k < 4) b = (k == 0) ? 8'hFF : (k == 1) ? h1 : (k == 2) ? h2 : 8'h00;
          else b = pat(j);
          expq.push_back({k == 0, b});
        end
        j++;
        if (midchg && j == 3) begin
          cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 16'd0;
        end
      end
      cyc++;
    end
    @(posedge clk); #1; smp_valid = 0; cfg_we = 0;
    if (midchg) set_ctrl(m_odd, m_even, m_all, m_hdr);
  endtask

  task automatic finish_test();
    @(posedge clk); #1; hs_mid = 1; line_num = 9'd300; eq_line = 1; fld_even = 0;
    @(posedge clk); #1; hs_mid = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(expq.size() == 0, {cur_tag, " missing bytes"}, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    #(5 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    chk(vbi_valid == 0, "R1 reset valid", vbi_valid, 0);
    // R1: disabled after reset
    run_line(0, 30, 0, 20, 0, 0);
    run_line(1, 31, 0, 20, 0, 0);
    finish_test();
    // R1 / R5: default start offset 7Ah
    set_ctrl(1, 0, 1, 0);
    run_line(0, 40, 0, 250, 0, 0);
    finish_test();
    // R5 small offset, R9 marker
    cur_tag = "R5";
    wr_cfg(2'd1, 16'd3); m_start = 3;
    wr_cfg(2'd2, 16'd20); m_lim = 20;
    run_line(0, 22, 0, 30, 0, 0);
    finish_test();
    // R2 field gating
    cur_tag = "R2";
    run_line(1, 22, 0, 30, 0, 0);
    run_line(0, 23, 0, 12, 0, 0);
    set_ctrl(0, 1, 1, 0);
    run_line(0, 24, 0, 12, 0, 0);
    run_line(1, 25, 0, 12, 0, 0);
    finish_test();
    // R3 equalization lines skipped in capture-all
    cur_tag = "R3";
    set_ctrl(1, 1, 1, 0);
    run_line(0, 4, 1, 12, 0, 0);
    run_line(1, 5, 0, 12, 0, 0);
    finish_test();
    // R4 mask mode
    cur_tag = "R4";
    set_ctrl(1, 1, 0, 0);
    wr_mask(21, 1);
    run_line(0, 21, 0, 12, 0, 0);
    run_line(0, 22, 0, 12, 0, 0);
    run_line(1, 21, 1, 12, 0, 0);
    finish_test();
    // R6 / R7 preamble with both parity cases, R9 on header
    cur_tag = "R7";
    set_ctrl(1, 1, 1, 1);
    run_line(1, 9'h1A5, 0, 16, 0, 0);
    run_line(0, 9'h015, 0, 16, 0, 0);
    chk(tb_tag({1'b1, 5'h1A}) == 8'hBA, "R7 cnt1 even-field", tb_tag({1'b1, 5'h1A}), 8'hBA);
    finish_test();
    // R8 slot limit, with and without header
    cur_tag = "R8";
    wr_cfg(2'd2, 16'd5); m_lim = 5;
    run_line(1, 60, 0, 30, 0, 0);
    set_ctrl(1, 1, 1, 0);
    run_line(0, 61, 0, 30, 0, 0);
    wr_cfg(2'd2, 16'd1000); m_lim = 1000;
    run_line(0, 62, 0, 15, 0, 0);
    finish_test();
    // R12 beat gaps
    cur_tag = "R12";
    set_ctrl(1, 1, 1, 1);
    run_line(0, 70, 0, 20, 1, 0);
    finish_test();
    // R10 mid-line register write ignored for current line
    cur_tag = "R10";
    run_line(1, 71, 0, 20, 0, 1);
    run_line(0, 72, 0, 20, 0, 0);
    finish_test();
    // R11 stall: directed
    cur_tag = "R11";
    set_ctrl(1, 1, 1, 0);
    wr_cfg(2'd1, 16'd1); m_start = 1;
    sb_on = 0;
    @(posedge clk); #1; hs_mid = 1; fld_even = 0; line_num = 9'd80; eq_line = 0; smp_valid = 1;
    for (int j = 0; j < 16; j++) begin
      @(posedge clk); #1;
      hs_mid = 0; smp_valid = 1; smp_data = pat(j);
      vbi_ready = !(j >= 8 && j <= 10);
      @(negedge clk);
      if (j >= 9 && j <= 11) begin
        chk(vbi_valid == 1, "R11 valid held", vbi_valid, 1);
        chk(vbi_data == pat(7), "R11 data held", vbi_data, pat(7));
      end
      if (j == 12) chk(vbi_data == pat(11), "R11 stalled slots dropped", vbi_data, pat(11));
    end
    @(posedge clk); #1; smp_valid = 0; vbi_ready = 1;
    finish_test();
    sb_on = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule